// File: doc/BRIEF.md
# SIMD Instruction Fault Checker

This block decides which architectural fault a 128-bit media arithmetic instruction raises. It looks at feature support, operating-system enable bits, the operating mode, the alignment of any memory operand, and the unmasked floating-point exception reported by the execution unit. When an instruction is presented with a one-cycle check strobe, the block reports one registered fault code on the next cycle, together with a one-cycle valid pulse.

The checks before execution are feature and control faults, the device-not-available fault and the alignment faults. The check after execution covers the floating-point exception. When several conditions hold at once, only the one with the highest priority is reported. Segment-limit, canonical-address and paging checks are handled elsewhere.

Top module: `simd_fault_chk`

## Requirements
- R1: One cycle after `chk_vld_i` is high, `flt_vld_o` pulses high for exactly one cycle with the fault code. Whenever `flt_vld_o` is low, `flt_code_o` is 0. Reset clears both. Codes: 0 none, 1 invalid opcode, 2 device not available, 3 general protection, 4 alignment check, 5 SIMD floating-point.
- R2: A single-precision form (`dbl_i`=0) with `feat_base_i`=0, or a double-precision form (`dbl_i`=1) with `feat_ext_i`=0, gives code 1. The feature bit of the other precision has no effect.
- R3: `cr0_em_i`=1 or `cr4_fxsr_en_i`=0 gives code 1.
- R4: `cr0_ts_i`=1 gives code 2 when neither R2 nor R3 applies.
- R5: A packed form (`packed_i`=1) with a memory operand whose address bits [3:0] are not zero, and with `mis_mode_i`=0, gives code 3 in every mode, whatever the value of `ac_en_i`.
- R6: A packed form with a misaligned memory operand and `mis_mode_i`=1 gives code 4 when `ac_en_i`=1 outside real mode. It gives no alignment fault when `ac_en_i`=0.
- R7: A scalar form never gives code 3. It gives code 4 when `ac_en_i`=1 outside real mode and the address is misaligned to its element size (bits [1:0] for single precision, bits [2:0] for double precision), whatever the value of `mis_mode_i`.
- R8: In real mode (`mode_i`=0) code 4 is never produced. `mode_i`=1 and `mode_i`=2 or 3 stand for virtual-8086 and protected.
- R9: With `mem_op_i`=0 there is no alignment fault, whatever the address bits are.
- R10: If no fault from R2 to R9 applies and `xf_pend_i`=1, the code is 5 when `cr4_xmm_exc_en_i`=1 and 1 when it is 0.
- R11: Priority runs from feature/control invalid opcode, to device not available, to alignment, to the check after execution. Any fault before execution suppresses the one after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chk_vld_i | input | 1 | Instruction presented for checking |
| feat_base_i | input | 1 | Base media set supported (single-precision forms) |
| feat_ext_i | input | 1 | Second-generation media set supported (double-precision forms) |
| dbl_i | input | 1 | Instruction is double precision |
| cr0_em_i | input | 1 | Emulation bit |
| cr0_ts_i | input | 1 | Task-switched bit |
| cr4_fxsr_en_i | input | 1 | OS enables media state save/restore |
| cr4_xmm_exc_en_i | input | 1 | OS enables SIMD floating-point exception reporting |
| mode_i | input | 2 | 0 real, 1 virtual-8086, 2/3 protected |
| mem_op_i | input | 1 | Instruction has a memory operand |
| addr_lo_i | input | 4 | Low address bits of the memory operand |
| packed_i | input | 1 | Packed form (1) or scalar form (0) |
| ac_en_i | input | 1 | Alignment checking enabled |
| mis_mode_i | input | 1 | Misaligned-access mode bit of the media control register |
| xf_pend_i | input | 1 | Unmasked floating-point exception from execution |
| flt_vld_o | output | 1 | Fault result strobe |
| flt_code_o | output | 3 | Fault code |

## Verification
The bench targets the places where the checks interact. A misaligned scalar access must not raise general protection, and a design that applies the 16-byte rule to every access would report code 3 there. In real mode, alignment checking is off while a packed misalignment still raises general protection, so a design that gates both faults by mode would miss one of the two cases. The feature bit is cross-checked against precision, and a design that reads the wrong feature bit would fault on a supported form. Stacked faults check that pending exceptions after execution are hidden by device-not-available and alignment faults, so a design with the wrong priority would report code 5 or code 1 instead of code 2 or code 3.

// File: rtl/simd_fault_pkg.sv
package simd_fault_pkg;
  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_UD   = 3'd1,
    FLT_NM   = 3'd2,
    FLT_GP   = 3'd3,
    FLT_AC   = 3'd4,
    FLT_XF   = 3'd5
  } flt_code_e;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_V86  = 2'd1,
    MODE_PROT = 2'd2,
    MODE_PRT2 = 2'd3
  } cpu_mode_e;

  localparam int unsigned VEC_BYTES_DEF = 16;
  localparam int unsigned SP_BYTES_DEF  = 4;
  localparam int unsigned DP_BYTES_DEF  = 8;
endpackage

// File: rtl/sfc_pre_chk.sv
module sfc_pre_chk (
  input  logic feat_base_i,
  input  logic feat_ext_i,
  input  logic dbl_i,
  input  logic cr0_em_i,
  input  logic cr0_ts_i,
  input  logic cr4_fxsr_en_i,
  output logic ud_o,
  output logic nm_o
);
  logic feat_ok;

  // precision selects which feature bit is required
  assign feat_ok = dbl_i ? feat_ext_i : feat_base_i;
  assign ud_o    = !feat_ok || cr0_em_i || !cr4_fxsr_en_i;
  assign nm_o    = cr0_ts_i;
endmodule

// File: rtl/sfc_align_chk.sv
module sfc_align_chk #(
  parameter int unsigned VEC_BYTES = 16,
  parameter int unsigned SP_BYTES  = 4,
  parameter int unsigned DP_BYTES  = 8,
  localparam int unsigned ADDR_LO_W = $clog2(VEC_BYTES)
) (
  input  logic                 mem_op_i,
  input  logic                 packed_i,
  input  logic                 dbl_i,
  input  logic [ADDR_LO_W-1:0] addr_lo_i,
  input  logic                 mis_mode_i,
  input  logic                 ac_en_i,
  input  logic                 real_mode_i,
  output logic                 gp_o,
  output logic                 ac_o
);
  localparam logic [ADDR_LO_W-1:0] VEC_MSK = ADDR_LO_W'(VEC_BYTES - 1);
  localparam logic [ADDR_LO_W-1:0] SP_MSK  = ADDR_LO_W'(SP_BYTES - 1);
  localparam logic [ADDR_LO_W-1:0] DP_MSK  = ADDR_LO_W'(DP_BYTES - 1);

  logic [ADDR_LO_W-1:0] elem_msk;
  logic                 vec_mis;
  logic                 elem_mis;
  logic                 ac_live;

  assign elem_msk = dbl_i ? DP_MSK : SP_MSK;
  assign vec_mis  = |(addr_lo_i & VEC_MSK);
  assign elem_mis = |(addr_lo_i & elem_msk);
  // alignment checking never fires in real mode
  assign ac_live  = ac_en_i && !real_mode_i;

  always_comb begin
    gp_o = 1'b0;
    ac_o = 1'b0;
    if (mem_op_i) begin
      if (packed_i) begin
        gp_o = vec_mis && !mis_mode_i;
        ac_o = vec_mis && mis_mode_i && ac_live;
      end else begin
        ac_o = elem_mis && ac_live;
      end
    end
  end
endmodule

// File: rtl/sfc_post_chk.sv
module sfc_post_chk (
  input  logic xf_pend_i,
  input  logic cr4_xmm_exc_en_i,
  output logic ud_o,
  output logic xf_o
);
  assign xf_o = xf_pend_i && cr4_xmm_exc_en_i;
  assign ud_o = xf_pend_i && !cr4_xmm_exc_en_i;
endmodule

// File: rtl/simd_fault_chk.sv
module simd_fault_chk
  import simd_fault_pkg::*;
#(
  parameter int unsigned VEC_BYTES = VEC_BYTES_DEF,
  parameter int unsigned SP_BYTES  = SP_BYTES_DEF,
  parameter int unsigned DP_BYTES  = DP_BYTES_DEF,
  localparam int unsigned ADDR_LO_W = $clog2(VEC_BYTES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 chk_vld_i,
  input  logic                 feat_base_i,
  input  logic                 feat_ext_i,
  input  logic                 dbl_i,
  input  logic                 cr0_em_i,
  input  logic                 cr0_ts_i,
  input  logic                 cr4_fxsr_en_i,
  input  logic                 cr4_xmm_exc_en_i,
  input  logic [1:0]           mode_i,
  input  logic                 mem_op_i,
  input  logic [ADDR_LO_W-1:0] addr_lo_i,
  input  logic                 packed_i,
  input  logic                 ac_en_i,
  input  logic                 mis_mode_i,
  input  logic                 xf_pend_i,
  output logic                 flt_vld_o,
  output logic [2:0]           flt_code_o
);
  logic      pre_ud, pre_nm, al_gp, al_ac, post_ud, post_xf;
  logic      real_mode;
  flt_code_e nxt_code;

  assign real_mode = (mode_i == MODE_REAL);

  sfc_pre_chk u_pre (
    .feat_base_i  (feat_base_i),
    .feat_ext_i   (feat_ext_i),
    .dbl_i        (dbl_i),
    .cr0_em_i     (cr0_em_i),
    .cr0_ts_i     (cr0_ts_i),
    .cr4_fxsr_en_i(cr4_fxsr_en_i),
    .ud_o         (pre_ud),
    .nm_o         (pre_nm)
  );

  sfc_align_chk #(
    .VEC_BYTES(VEC_BYTES),
    .SP_BYTES (SP_BYTES),
    .DP_BYTES (DP_BYTES)
  ) u_align (
    .mem_op_i   (mem_op_i),
    .packed_i   (packed_i),
    .dbl_i      (dbl_i),
    .addr_lo_i  (addr_lo_i),
    .mis_mode_i (mis_mode_i),
    .ac_en_i    (ac_en_i),
    .real_mode_i(real_mode),
    .gp_o       (al_gp),
    .ac_o       (al_ac)
  );

  sfc_post_chk u_post (
    .xf_pend_i       (xf_pend_i),
    .cr4_xmm_exc_en_i(cr4_xmm_exc_en_i),
    .ud_o            (post_ud),
    .xf_o            (post_xf)
  );

  // fixed priority: control/feature, task switch, alignment, post-execution
  always_comb begin
    if (pre_ud)       nxt_code = FLT_UD;
    else if (pre_nm)  nxt_code = FLT_NM;
    else if (al_gp)   nxt_code = FLT_GP;
    else if (al_ac)   nxt_code = FLT_AC;
    else if (post_xf) nxt_code = FLT_XF;
    else if (post_ud) nxt_code = FLT_UD;
    else              nxt_code = FLT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_vld_o  <= 1'b0;
      flt_code_o <= FLT_NONE;
    end else begin
      flt_vld_o  <= chk_vld_i;
      flt_code_o <= chk_vld_i ? nxt_code : FLT_NONE;
    end
  end

  assert_vld_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_vld_i |=> flt_vld_o);
  assert_vld_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_vld_i |=> !flt_vld_o);
  assert_code_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flt_vld_o |-> flt_code_o == FLT_NONE);
  assert_em_ud_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_vld_i && cr0_em_i |=> flt_code_o == FLT_UD);
  assert_ts_nm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_vld_i && cr0_ts_i && !cr0_em_i && cr4_fxsr_en_i && feat_base_i && feat_ext_i
    |=> flt_code_o == FLT_NM);
  assert_scalar_no_gp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_vld_i && !packed_i |=> flt_code_o != FLT_GP);
  assert_real_no_ac_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_vld_i && mode_i == MODE_REAL |=> flt_code_o != FLT_AC);
  assert_no_mem_no_align_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_vld_i && !mem_op_i |=> flt_code_o != FLT_GP && flt_code_o != FLT_AC);
endmodule

// File: tb/sim_simd_fault_chk.sv
module sim_simd_fault_chk;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chk_vld, feat_base, feat_ext, dbl, em, ts, fxsr_en, xmm_en;
  logic [1:0] mode;
  logic       mem_op, pkd, ac_en, mm, xf;
  logic [3:0] addr_lo;
  logic       flt_vld;
  logic [2:0] flt_code;
  int         n_chk = 0;
  int         n_fail = 0;

  localparam logic [2:0] C_NONE = 3'd0, C_UD = 3'd1, C_NM = 3'd2,
                         C_GP = 3'd3, C_AC = 3'd4, C_XF = 3'd5;

  always #2 clk = ~clk;

  simd_fault_chk u0 (
    .clk_i(clk), .rst_ni(rst_n), .chk_vld_i(chk_vld),
    .feat_base_i(feat_base), .feat_ext_i(feat_ext), .dbl_i(dbl),
    .cr0_em_i(em), .cr0_ts_i(ts), .cr4_fxsr_en_i(fxsr_en),
    .cr4_xmm_exc_en_i(xmm_en), .mode_i(mode), .mem_op_i(mem_op),
    .addr_lo_i(addr_lo), .packed_i(pkd), .ac_en_i(ac_en),
    .mis_mode_i(mm), .xf_pend_i(xf), .flt_vld_o(flt_vld), .flt_code_o(flt_code)
  );

  task automatic check(input logic [2:0] act, input logic [2:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clean();
    feat_base = 1; feat_ext = 1; dbl = 0; em = 0; ts = 0; fxsr_en = 1; xmm_en = 1;
    mode = 2'd2; mem_op = 0; addr_lo = 4'd0; pkd = 1; ac_en = 0; mm = 0; xf = 0;
  endtask

  task automatic issue(input logic [2:0] exp, input string tag);
    @(negedge clk); chk_vld = 1;
    @(negedge clk); chk_vld = 0;
    check({2'b0, flt_vld}, 3'd1, {tag, " vld"});
    check(flt_code, exp, tag);
  endtask

  task automatic t_reset();
    check({2'b0, flt_vld}, 3'd0, "R1 reset vld");
    check(flt_code, C_NONE, "R1 reset code");
  endtask

  task automatic t_idle();
    clean(); em = 1;
    issue(C_UD, "R1 pulse");
    @(negedge clk);
    check({2'b0, flt_vld}, 3'd0, "R1 single pulse");
    check(flt_code, C_NONE, "R1 idle code");
  endtask

  task automatic t_feature();
    clean(); feat_base = 0; issue(C_UD, "R2 single missing");
    dbl = 1; issue(C_NONE, "R2 double ignores base bit");
    feat_base = 1; feat_ext = 0; issue(C_UD, "R2 double missing");
    dbl = 0; issue(C_NONE, "R2 single ignores ext bit");
  endtask

  task automatic t_ctrl();
    clean(); em = 1; issue(C_UD, "R3 em");
    clean(); fxsr_en = 0; issue(C_UD, "R3 fxsr off");
  endtask

  task automatic t_nm();
    clean(); ts = 1; issue(C_NM, "R4 ts");
    em = 1; issue(C_UD, "R11 ud over nm");
  endtask

  task automatic t_packed();
    clean(); mem_op = 1; addr_lo = 4'd8; ac_en = 1; issue(C_GP, "R5 misaligned mm0 ac on");
    ac_en = 0; issue(C_GP, "R5 misaligned mm0 ac off");
    addr_lo = 4'd0; issue(C_NONE, "R5 aligned");
    addr_lo = 4'd4; mm = 1; ac_en = 1; issue(C_AC, "R6 mm1 ac on");
    ac_en = 0; issue(C_NONE, "R6 mm1 ac off");
  endtask

  task automatic t_scalar();
    clean(); pkd = 0; mem_op = 1; addr_lo = 4'd4; issue(C_NONE, "R7 scalar no gp");
    addr_lo = 4'd2; ac_en = 1; issue(C_AC, "R7 single misaligned");
    addr_lo = 4'd4; issue(C_NONE, "R7 single aligned at 4");
    dbl = 1; issue(C_AC, "R7 double misaligned at 4");
    addr_lo = 4'd8; issue(C_NONE, "R7 double aligned at 8");
    addr_lo = 4'd1; mm = 1; issue(C_AC, "R7 mm ignored");
  endtask

  task automatic t_real();
    clean(); mode = 2'd0; mem_op = 1; addr_lo = 4'd4; mm = 1; ac_en = 1;
    issue(C_NONE, "R8 packed ac real");
    mm = 0; issue(C_GP, "R8 gp in real");
    pkd = 0; addr_lo = 4'd1; issue(C_NONE, "R8 scalar ac real");
    mode = 2'd1; issue(C_AC, "R8 scalar ac v86");
  endtask

  task automatic t_nomem();
    clean(); addr_lo = 4'd4; issue(C_NONE, "R9 packed no mem");
    pkd = 0; ac_en = 1; addr_lo = 4'd3; issue(C_NONE, "R9 scalar no mem");
  endtask

  task automatic t_post();
    clean(); xf = 1; issue(C_XF, "R10 reporting on");
    xmm_en = 0; issue(C_UD, "R10 reporting off");
  endtask

  task automatic t_prio();
    clean(); xf = 1; ts = 1; issue(C_NM, "R11 nm over xf");
    clean(); xf = 1; mem_op = 1; addr_lo = 4'd8; issue(C_GP, "R11 gp over xf");
    mm = 1; ac_en = 1; xmm_en = 0; issue(C_AC, "R11 ac over post ud");
    clean(); xf = 1; feat_base = 0; issue(C_UD, "R11 feature ud over xf");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    chk_vld = 0;
    clean();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_idle();
    t_feature();
    t_ctrl();
    t_nm();
    t_packed();
    t_scalar();
    t_real();
    t_nomem();
    t_post();
    t_prio();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule